// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A host presents a character with a one-cycle write strobe. The character goes into a holding register. When the serial shifter is free, it takes the character from the holding register, so one character can wait while another is on the line.

The frame format comes from configuration inputs: 5 to 8 data bits; parity that is absent, even, odd or forced to a fixed level; and one, one-and-a-half or two stop bits. The format is captured when each frame starts.

Bit timing comes from a 16x oversample tick. The tick is derived from the system clock and a 16-bit divider that is supplied as a high byte and a low byte. An optional clear-to-send gate holds back new frames.

Two status outputs are provided. One reports that the holding register can accept a character. The other reports that the whole transmit path is empty.

Top module: `serial_tx`

## Requirements
- R1: While reset is asserted and after it is released, tx_o is 1 (the idle level), hold_empty_o is 1 and all_empty_o is 1.
- R2: Each frame is sent in this order: a start bit at 0, then the data bits least significant bit first, then the parity bit when parity is enabled, then the stop bits at 1. The first tick at which a character is waiting and sending is allowed starts the frame.
- R3: data_bits_i selects the number of data bits: 0 gives 5 bits, 1 gives 6 bits, 2 gives 7 bits and 3 gives 8 bits. Bits of wr_data_i above the selected length are not sent.
- R4: parity_i selects the parity bit: 0 sends no parity bit; 1 sends even parity (the data bits plus the parity bit hold an even number of ones); 2 sends odd parity; 3 sends force_par_i in every frame.
- R5: stop_i selects the stop length: 0 gives 16 ticks, 1 gives 24 ticks (1.5 bits), and 2 or 3 give 32 ticks.
- R6: A tick occurs once every 2*D system clocks, where D = {div_hi_i, div_lo_i}; a D of 0 is treated as 1. Each start, data and parity bit lasts 16 ticks, which is 32*D clocks.
- R7: hold_empty_o is 1 exactly when the holding register is empty. It goes low in the cycle after an accepted write and goes high again in the cycle after the shifter takes the character.
- R8: all_empty_o is 1 only when the holding register is empty and no frame is in progress. It goes high in the cycle after the tick that ends the last stop bit, provided no character is waiting.
- R9: A write made while hold_empty_o is 0 is ignored. The character already waiting is the one that is sent.
- R10: When cts_en_i is 1, a new frame starts only at a tick where cts_ok_i is 1. A frame already in progress runs to its end.
- R11: If a character is waiting and sending is allowed at the tick that ends a stop period, the next start bit begins at that same tick, with no idle time in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_hi_i | input | 8 | High byte of the bit-rate divider |
| div_lo_i | input | 8 | Low byte of the bit-rate divider |
| data_bits_i | input | 2 | Data length select (5 to 8 bits) |
| parity_i | input | 2 | Parity mode select |
| force_par_i | input | 1 | Parity level used when parity is forced |
| stop_i | input | 2 | Stop length select |
| cts_en_i | input | 1 | Enables the clear-to-send gate |
| cts_ok_i | input | 1 | 1 = sending is allowed |
| wr_i | input | 1 | Write strobe for a character |
| wr_data_i | input | 8 | Character to send |
| tx_o | output | 1 | Serial line |
| hold_empty_o | output | 1 | Holding register can accept a character |
| all_empty_o | output | 1 | Holding register and shifter are both empty |

## Verification
A wrong internal state shows up on tx_o within one tick. Examples are a shifter that loses its bit position, a parity bit latched with the wrong sense, or a stop counter with the wrong limit. Each of these moves a level edge, and the next clock's comparison against the reference waveform catches it.

A holding register that fails to clear, or that takes a second write, shows up on hold_empty_o in the following cycle. It also shows up as a wrong character once that frame reaches the line.

A frame whose end is counted wrongly shows up on all_empty_o, and on the start time of a back-to-back frame, within the same tick.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_FORCE = 2'd3
  } par_mode_e;

  localparam int unsigned OVS = 16;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // a divider of 0 behaves as 1; one tick per 2*div clocks
  always_comb begin
    lim = {(div_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_i, 1'b0};
  end

  assign tick_o = (cnt_q >= lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  assert_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> (!full_q || $stable(data_q)));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hold_full_i,
  input  logic [DW-1:0] hold_data_i,
  input  logic [1:0]    data_bits_i,
  input  logic [1:0]    parity_i,
  input  logic          force_par_i,
  input  logic [1:0]    stop_i,
  input  logic          cts_en_i,
  input  logic          cts_ok_i,
  output logic          take_o,
  output logic          tx_o,
  output logic          idle_o
);
  localparam int unsigned SUB_W = $clog2(2*OVS);
  localparam int unsigned BIT_W = $clog2(DW);

  tx_state_e         state_q;
  logic [SUB_W-1:0]  sub_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DW-1:0]     sh_q;
  logic [1:0]        dbits_q;
  logic [1:0]        stop_q;
  logic              par_en_q;
  logic              par_q;
  logic [SUB_W-1:0]  last_sub;
  logic              last;
  logic              can_go;
  logic              launch;
  logic [DW-1:0]     mask;
  logic              par_new;

  always_comb begin
    last_sub = SUB_W'(OVS - 1);
    if (state_q == ST_STOP) begin
      unique case (stop_q)
        2'd0:    last_sub = SUB_W'(OVS - 1);
        2'd1:    last_sub = SUB_W'(OVS + OVS/2 - 1);
        default: last_sub = SUB_W'(2*OVS - 1);
      endcase
    end
  end

  assign last   = (sub_q == last_sub);
  assign can_go = hold_full_i && (!cts_en_i || cts_ok_i);
  assign launch = tick_i && can_go &&
                  ((state_q == ST_IDLE) || (state_q == ST_STOP && last));

  always_comb begin
    mask = {DW{1'b1}} >> (2'd3 - data_bits_i);
    unique case (par_mode_e'(parity_i))
      PAR_EVEN:  par_new = ^(hold_data_i & mask);
      PAR_ODD:   par_new = ~^(hold_data_i & mask);
      PAR_FORCE: par_new = force_par_i;
      default:   par_new = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sub_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      dbits_q  <= '0;
      stop_q   <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
    end else if (launch) begin
      state_q  <= ST_START;
      sub_q    <= '0;
      sh_q     <= hold_data_i;
      dbits_q  <= data_bits_i;
      stop_q   <= stop_i;
      par_en_q <= (parity_i != PAR_NONE);
      par_q    <= par_new;
    end else if (tick_i && state_q != ST_IDLE) begin
      if (!last) begin
        sub_q <= sub_q + 1'b1;
      end else begin
        sub_q <= '0;
        unique case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            bit_q   <= '0;
          end
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if (bit_q == BIT_W'({1'b0, dbits_q}) + BIT_W'(4))
              state_q <= par_en_q ? ST_PAR : ST_STOP;
            else
              bit_q <= bit_q + 1'b1;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      ST_PAR:   tx_o = par_q;
      default:  tx_o = 1'b1;
    endcase
  end

  assign take_o = launch;
  assign idle_o = (state_q == ST_IDLE);

  assert_sub_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sub_q));
  assert_cts_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_START) |-> $past(!cts_en_i || cts_ok_i));
  assert_launch_takes_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_START) |-> $past(hold_full_i));
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    div_hi_i,
  input  logic [7:0]    div_lo_i,
  input  logic [1:0]    data_bits_i,
  input  logic [1:0]    parity_i,
  input  logic          force_par_i,
  input  logic [1:0]    stop_i,
  input  logic          cts_en_i,
  input  logic          cts_ok_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          tx_o,
  output logic          hold_empty_o,
  output logic          all_empty_o
);
  logic          tick;
  logic          take;
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          sh_idle;

  sertx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (DIV_W'({div_hi_i, div_lo_i})),
    .tick_o (tick)
  );

  sertx_hold #(.DW(DW)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .data_i (wr_data_i),
    .take_i (take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  sertx_shift #(.DW(DW)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .data_bits_i (data_bits_i),
    .parity_i    (parity_i),
    .force_par_i (force_par_i),
    .stop_i      (stop_i),
    .cts_en_i    (cts_en_i),
    .cts_ok_i    (cts_ok_i),
    .take_o      (take),
    .tx_o        (tx_o),
    .idle_o      (sh_idle)
  );

  assign hold_empty_o = !hold_full;
  assign all_empty_o  = !hold_full && sh_idle;

  assert_empty_line_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_empty_o |-> tx_o);
endmodule

// File: tb/test_serial_tx.sv
module test_serial_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_hi = 8'd0, div_lo = 8'd1;
  logic [1:0] dbits = 2'd3, par = 2'd0, stop = 2'd0;
  logic       fpar = 1'b0, cts_en = 1'b0, cts_ok = 1'b1;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       tx, hold_empty, all_empty;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  serial_tx i_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .div_hi_i(div_hi), .div_lo_i(div_lo),
    .data_bits_i(dbits), .parity_i(par), .force_par_i(fpar), .stop_i(stop),
    .cts_en_i(cts_en), .cts_ok_i(cts_ok), .wr_i(wr), .wr_data_i(wdata),
    .tx_o(tx), .hold_empty_o(hold_empty), .all_empty_o(all_empty)
  );

  always #10 clk = ~clk;

  // behavioural reference: queue of line levels, one entry per tick
  bit   q[$];
  int   m_cnt = 0;
  bit   m_line = 1'b1, m_hold = 1'b0, m_busy = 1'b0;
  logic [7:0] m_data = 8'h00;

  task automatic build_frame();
    int  nb;
    int  ones;
    bit  pb;
    int  slen;
    nb = 5 + int'(dbits);
    ones = 0;
    for (int k = 0; k < 16; k++) q.push_back(1'b0);
    for (int b = 0; b < nb; b++) begin
      ones += int'(m_data[b]);
      for (int k = 0; k < 16; k++) q.push_back(m_data[b]);
    end
    if (par != 2'd0) begin
      pb = (par == 2'd1) ? bit'(ones % 2) :
           (par == 2'd2) ? bit'((ones + 1) % 2) : fpar;
      for (int k = 0; k < 16; k++) q.push_back(pb);
    end
    slen = (stop == 2'd0) ? 16 : (stop == 2'd1) ? 24 : 32;
    for (int k = 0; k < slen; k++) q.push_back(1'b1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_cnt = 0; m_line = 1'b1; m_hold = 1'b0; m_busy = 1'b0; m_data = 8'h00;
    end else begin
      int  d;
      bit  tk;
      bit  old_hold;
      d = {div_hi, div_lo};
      if (d == 0) d = 1;
      tk = (m_cnt >= 2*d - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      old_hold = m_hold;
      if (tk) begin
        if (q.size() > 0) begin
          m_line = q.pop_front();
        end else if (old_hold && (!cts_en || cts_ok)) begin
          build_frame();
          m_line = q.pop_front();
          m_busy = 1'b1;
          m_hold = 1'b0;
        end else begin
          m_line = 1'b1;
          m_busy = 1'b0;
        end
      end
      if (wr && !old_hold) begin
        m_hold = 1'b1;
        m_data = wdata;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cycles, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, tx, m_line);
      check("R7", hold_empty, !m_hold);
      check("R8", all_empty, !m_hold && !m_busy);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog at cycle %0d: actual=running expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic put(input logic [7:0] v);
    while (!hold_empty) @(negedge clk);
    wr = 1'b1; wdata = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!all_empty) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] b, input logic [1:0] p,
                     input logic f, input logic [1:0] s);
    dbits = b; par = p; fpar = f; stop = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", tx, 1'b1);
    check("R1", hold_empty, 1'b1);
    check("R1", all_empty, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", tx, 1'b1);

    cur_req = "R2"; cfg(2'd3, 2'd0, 1'b0, 2'd0); put(8'hA5); drain();
    cur_req = "R3"; cfg(2'd0, 2'd1, 1'b0, 2'd0); put(8'hF3); drain();
    cfg(2'd1, 2'd0, 1'b0, 2'd0); put(8'hC6); drain();
    cur_req = "R4"; cfg(2'd2, 2'd2, 1'b0, 2'd0); put(8'h55); drain();
    cfg(2'd3, 2'd1, 1'b0, 2'd0); put(8'h81); drain();
    cfg(2'd1, 2'd3, 1'b1, 2'd0); put(8'h00); drain();
    cfg(2'd3, 2'd3, 1'b0, 2'd0); put(8'hFF); drain();
    cur_req = "R5"; cfg(2'd3, 2'd1, 1'b0, 2'd1); put(8'h3C); put(8'h0F); drain();
    cfg(2'd3, 2'd0, 1'b0, 2'd2); put(8'h96); put(8'h69); drain();
    cfg(2'd3, 2'd0, 1'b0, 2'd3); put(8'h01); drain();

    cur_req = "R6"; div_lo = 8'd3; cfg(2'd3, 2'd2, 1'b0, 2'd0); put(8'h0F); drain();
    div_lo = 8'd0; put(8'hE1); drain();
    div_lo = 8'd1;

    // second write while holding register is full must be dropped
    cur_req = "R9"; div_lo = 8'd4;
    put(8'h11);
    while (!hold_empty) @(negedge clk);
    wr = 1'b1; wdata = 8'h22; @(negedge clk);
    wdata = 8'h33; @(negedge clk);
    wdata = 8'h44; @(negedge clk);
    wr = 1'b0;
    drain();
    div_lo = 8'd1;

    cur_req = "R11"; cfg(2'd3, 2'd1, 1'b0, 2'd0);
    put(8'h5A); put(8'hA5); put(8'hC3); drain();

    cur_req = "R10"; cts_en = 1'b1; cts_ok = 1'b0;
    put(8'h77);
    repeat (600) @(negedge clk);
    check("R10", tx, 1'b1);
    check("R10", hold_empty, 1'b0);
    cts_ok = 1'b1;
    repeat (40) @(negedge clk);
    cts_ok = 1'b0;   // frame in progress must finish
    repeat (600) @(negedge clk);
    check("R10", all_empty, 1'b1);
    put(8'h99);
    repeat (200) @(negedge clk);
    cts_ok = 1'b1; drain();
    cts_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule